// File: doc/BRIEF.md
# Transmit Polarity Inversion and Word-Boundary Slip Stage

This stage sits between the encoder's parallel output and the serializer of a serial transmitter. Each parallel clock it takes one word of `W` bits (10 by default, 8 as the narrow variant) and passes one word on. Along the way it can complement every bit of the word, which swaps the line polarity. It can also delay the serial stream by 0 to `W-1` bit times. It does this by building each output word from the tail of the previous input word and the head of the current one.

Both the invert control and the slip count arrive asynchronously to the parallel clock. Each control passes through a two-stage synchronizer. A new value is adopted only when two consecutive synchronized samples agree, so a short glitch, or a multi-bit count caught mid-transition, never reaches the datapath. A slip count above `W-1` saturates at `W-1`. The output is a register. Every word appears at the output two clock edges after it was sampled, whatever the settings.

Top module: `txps_top`

## Requirements
- R1: While `rst_n` is low, `word_out` is all zeros. The invert setting and the slip count restart at "off" and 0.
- R2: With slip 0 and invert off, `word_out` after clock edge k+1 equals the `word_in` sampled at edge k: the latency is two edges.
- R3: With the qualified invert setting high, every bit of `word_out` is the complement of the value it would have with invert off.
- R4: The invert control is adopted only when two consecutive synchronized samples agree. A pulse one clock long has no effect on `word_out`. A pulse held for two clocks inverts at least one output word.
- R5: With slip count n, and with cur the word sampled at edge k and prev the word sampled at edge k-1, output bit i after edge k+1 is prev[W-n+i] for i < n and cur[i-n] for i >= n. Bit 0 is the first bit serialized.
- R6: A slip count above W-1 (for example 12 or 15 when W = 10) behaves exactly as W-1.
- R7: A slip count value present on `slip_async` for only one clock is ignored. The output keeps following the previously adopted count.
- R8: When the slip count changes, every output word equals the result for either the old count or the new count, never a mixture of the two.
- R9: With W = 8, inversion complements all 8 bits and slip counts above 7 behave as 7.
- R10: Invert and slip combine: the output is the complement of the R5 result for the adopted count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_in | input | W | Encoded parallel word from the encoder |
| inv_async | input | 1 | Asynchronous polarity invert request, active high |
| slip_async | input | CW | Asynchronous slip count in bits (0 to W-1, larger saturates) |
| word_out | output | W | Word handed to the serializer |

## Verification
The bench checks every slip count from 1 to 9 against a bit-by-bit model on pseudo-random words. A reversed shift direction or an off-by-one offset would put the wrong bits of the previous word into the low positions and fail on every count. It drives invert pulses of one and two clocks. A design without the agreement filter would flip on the single-clock pulse, and an over-strict filter would miss the two-clock pulse. It drives a one-clock spike on the slip count, and it makes a count change while words stream. A design that adopts unqualified or partly settled counts would emit words that match neither count. It drives counts of 12 and 15, which would produce negative shifts without saturation. The narrow 8-bit instance checks that inversion and saturation follow the width parameter.

// File: rtl/txps_pkg.sv
package txps_pkg;

  // Default geometry of the stage.
  localparam int WORD_W_DEF  = 10;
  localparam int COUNT_W_DEF = 4;

  // Saturate a requested slip count at the largest legal value.
  function automatic int sat_slip(input int req, input int top);
    return (req > top) ? top : req;
  endfunction

endpackage

// File: rtl/txps_sync.sv
module txps_sync #(
  parameter int N      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_async,
  output logic [N-1:0] d_sync
);

  logic [N-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/txps_qual.sv
module txps_qual #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ctl_async,
  output logic [N-1:0] ctl_q
);

  logic [N-1:0] smp;
  logic [N-1:0] smp_d;
  logic         agree;

  txps_sync #(.N(N), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (ctl_async),
    .d_sync  (smp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) smp_d <= '0;
    else        smp_d <= smp;
  end

  // Two successive synchronized samples must match before adoption.
  assign agree = (smp == smp_d);

  always_ff @(posedge clk) begin
    if (!rst_n)     ctl_q <= '0;
    else if (agree) ctl_q <= smp;
  end

  // R4 R7
  q_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_q) |-> $past(agree));

endmodule

// File: rtl/txps_slip.sv
module txps_slip #(
  parameter int W  = 10,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] n,
  input  logic          inv,
  output logic [W-1:0]  dout
);

  localparam int TOP = W - 1;

  logic [W-1:0] cur_w;
  logic [W-1:0] prev_w;
  logic [W-1:0] joined;
  logic [W-1:0] flipped;
  logic [1:0]   warm;

  // Take W bits out of {cur, prev}, n bits below the cur boundary.
  function automatic logic [W-1:0] join_words(input logic [W-1:0] c,
                                              input logic [W-1:0] p,
                                              input int k);
    logic [2*W-1:0] cat;
    cat = {c, p} >> (W - k);
    return cat[W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_w  <= '0;
      prev_w <= '0;
    end else begin
      cur_w  <= din;
      prev_w <= cur_w;
    end
  end

  assign joined  = join_words(cur_w, prev_w, int'(n));
  assign flipped = joined ^ {W{inv}};

  // Whole word registered: count and polarity switch on word edges only.
  always_ff @(posedge clk) begin
    if (!rst_n) dout <= '0;
    else        dout <= flipped;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(n) <= TOP);

  // R2
  pass_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && $past(n) == '0 && !$past(inv)) |-> dout == $past(din, 2));

  // R3
  inv_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && $past(n) == '0 && $past(inv)) |-> dout == ~$past(din, 2));

  // R1
  rst_zero_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> dout == '0);

endmodule

// File: rtl/txps_top.sv
module txps_top #(
  parameter int W  = txps_pkg::WORD_W_DEF,
  parameter int CW = txps_pkg::COUNT_W_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  word_in,
  input  logic          inv_async,
  input  logic [CW-1:0] slip_async,
  output logic [W-1:0]  word_out
);

  localparam int MAXS = W - 1;

  logic          inv_q;
  logic [CW-1:0] slip_q;
  logic [CW-1:0] slip_n;

  txps_qual #(.N(1)) u_inv (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_async (inv_async),
    .ctl_q     (inv_q)
  );

  txps_qual #(.N(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_async (slip_async),
    .ctl_q     (slip_q)
  );

  assign slip_n = CW'(txps_pkg::sat_slip(int'(slip_q), MAXS));

  txps_slip #(.W(W), .CW(CW)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (word_in),
    .n     (slip_n),
    .inv   (inv_q),
    .dout  (word_out)
  );

  // R6
  sat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(slip_q) <= MAXS) |-> slip_n == slip_q);

endmodule

// File: tb/sim_txps_top.sv
module sim_txps_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] word_in = '0;
  logic       inv_a = 1'b0;
  logic [3:0] slip_a = '0;
  logic [9:0] word_out;

  logic [7:0] w8_in = '0;
  logic       inv8 = 1'b0;
  logic [3:0] slip8 = '0;
  logic [7:0] w8_out;

  int n_cmp = 0;
  int n_bad = 0;

  logic [9:0] h0 = '0, h1 = '0, h2 = '0;
  logic [9:0] snap_cur, snap_prev, got;
  logic [9:0] lfsr = 10'h15B;

  always #10 clk = ~clk;

  txps_top #(.W(10), .CW(4)) u0 (
    .clk(clk), .rst_n(rst_n), .word_in(word_in),
    .inv_async(inv_a), .slip_async(slip_a), .word_out(word_out));

  txps_top #(.W(8), .CW(4)) u1 (
    .clk(clk), .rst_n(rst_n), .word_in(w8_in),
    .inv_async(inv8), .slip_async(slip8), .word_out(w8_out));

  function automatic logic [9:0] mdl(input logic [9:0] c, input logic [9:0] p,
                                     input int k, input bit inv);
    logic [9:0] r;
    for (int i = 0; i < 10; i++) r[i] = (i < k) ? p[10 - k + i] : c[i - k];
    return inv ? ~r : r;
  endfunction

  function automatic logic [9:0] next_rand(input logic [9:0] v);
    return {v[8:0], v[9] ^ v[6]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [9:0] act,
                     input logic [9:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // One clock: sample output at the negedge, then drive the next word.
  task automatic step(input logic [9:0] w);
    @(negedge clk);
    got       = word_out;
    snap_cur  = h1;
    snap_prev = h2;
    word_in   = w;
    h2 = h1; h1 = h0; h0 = w;
  endtask

  task automatic rnd_step();
    lfsr = next_rand(lfsr);
    step(lfsr);
  endtask

  task automatic settle();
    for (int i = 0; i < 8; i++) rnd_step();
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(word_out == '0, "R1 reset out", word_out, '0);
    chk(w8_out == '0, "R1 reset out w8", {2'b0, w8_out}, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_pass();
    inv_a = 0; slip_a = 0; settle();
    for (int i = 0; i < 16; i++) begin
      rnd_step();
      chk(got == snap_cur, "R2 passthrough", got, snap_cur);
    end
  endtask

  task automatic t_invert();
    inv_a = 1; slip_a = 0; settle();
    for (int i = 0; i < 10; i++) begin
      rnd_step();
      chk(got == ~snap_cur, "R3 invert", got, ~snap_cur);
    end
    inv_a = 0; settle();
  endtask

  task automatic t_pulse(input int len, input bit expect_hit);
    int hits = 0;
    logic [9:0] c = 10'h2B3;
    inv_a = 0; slip_a = 0;
    for (int i = 0; i < 8; i++) step(c);
    inv_a = 1;
    for (int i = 0; i < len; i++) step(c);
    inv_a = 0;
    for (int i = 0; i < 12; i++) begin
      step(c);
      if (got == ~c) hits++;
    end
    if (expect_hit) chk(hits >= 1, "R4 two-clock pulse", 10'(hits), 10'd1);
    else            chk(hits == 0, "R4 one-clock pulse", 10'(hits), 10'd0);
  endtask

  task automatic t_slip_all();
    inv_a = 0;
    for (int k = 1; k <= 9; k++) begin
      slip_a = 4'(k); settle();
      for (int i = 0; i < 6; i++) begin
        rnd_step();
        chk(got == mdl(snap_cur, snap_prev, k, 0), "R5 slip", got,
            mdl(snap_cur, snap_prev, k, 0));
      end
    end
  endtask

  task automatic t_sat(input logic [3:0] v);
    inv_a = 0; slip_a = v; settle();
    for (int i = 0; i < 5; i++) begin
      rnd_step();
      chk(got == mdl(snap_cur, snap_prev, 9, 0), "R6 saturate", got,
          mdl(snap_cur, snap_prev, 9, 0));
    end
  endtask

  task automatic t_spike();
    inv_a = 0; slip_a = 3; settle();
    slip_a = 6; rnd_step();
    slip_a = 3;
    for (int i = 0; i < 12; i++) begin
      rnd_step();
      chk(got == mdl(snap_cur, snap_prev, 3, 0), "R7 count spike", got,
          mdl(snap_cur, snap_prev, 3, 0));
    end
  endtask

  task automatic t_switch();
    logic [9:0] a, b;
    inv_a = 0; slip_a = 2; settle();
    slip_a = 7;
    for (int i = 0; i < 10; i++) begin
      rnd_step();
      a = mdl(snap_cur, snap_prev, 2, 0);
      b = mdl(snap_cur, snap_prev, 7, 0);
      chk(got == a || got == b, "R8 whole-word switch", got, b);
    end
    rnd_step();
    b = mdl(snap_cur, snap_prev, 7, 0);
    chk(got == b, "R8 new count adopted", got, b);
  endtask

  task automatic t_combo();
    inv_a = 1; slip_a = 5; settle();
    for (int i = 0; i < 8; i++) begin
      rnd_step();
      chk(got == mdl(snap_cur, snap_prev, 5, 1), "R10 invert plus slip", got,
          mdl(snap_cur, snap_prev, 5, 1));
    end
    inv_a = 0; slip_a = 0; settle();
  endtask

  // Constant A5 on the narrow instance: saturated count 7 gives D2, invert gives 5A.
  task automatic t_narrow();
    w8_in = 8'hA5; inv8 = 0; slip8 = 4'd9;
    repeat (10) @(negedge clk);
    chk(w8_out == 8'hD2, "R9 narrow saturate", {2'b0, w8_out}, 10'h0D2);
    inv8 = 1; slip8 = 0;
    repeat (10) @(negedge clk);
    chk(w8_out == 8'h5A, "R9 narrow invert", {2'b0, w8_out}, 10'h05A);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_pass();
    t_invert();
    t_pulse(1, 0);
    t_pulse(2, 1);
    t_slip_all();
    t_sat(4'd12);
    t_sat(4'd15);
    t_spike();
    t_switch();
    t_combo();
    t_narrow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule